// File: doc/BRIEF.md
# Deferred-Select Integer Datapath

This block is the integer arithmetic slice of a six-stage in-order core. It spans the execute, memory and writeback stages. In execute, three units work side by side on the same operand pair: an adder/subtractor that also produces set-less-than flags, a bitwise logic unit, and a barrel shifter. None of their results is chosen in execute. All three are registered into the memory stage, and only there does a result-select multiplexer pick one.

The memory-access address is taken straight from the registered adder result, so the address never waits on the result multiplexer. In writeback, a second multiplexer chooses what goes to the register file: the selected arithmetic result, load data returned by the memory bus, or the link value (PC plus four) for jump-and-link instructions. Each instruction's select codes travel down the pipeline with it, so every multiplexer is steered by the instruction it currently holds. Decode, the bus and the register file lie outside the block.

Top module: `split_alu_dp`

## Requirements
- R1: An instruction presented with `ex_valid` high before clock edge n shows `mem_valid` high after edge n and `wb_valid` high after edge n+1. A cycle with `ex_valid` low produces no valid stage. While `rst_n` is low, both `mem_valid` and `wb_valid` are low.
- R2: Adder code `ex_add_op` 0 gives a+b and code 1 gives a-b, both modulo 2^XLEN.
- R3: Adder code 2 gives 1 when a < b as two's-complement signed values, and 0 otherwise. Code 3 does the same comparison unsigned. The result is zero-extended to XLEN bits.
- R4: Logic code `ex_logic_op` 0 gives a XOR b, 1 gives a OR b, 2 gives a AND b, and 3 gives zero.
- R5: Shift code `ex_shift_op` 0 shifts a left, 1 shifts it right logically, 2 shifts it right arithmetically, and 3 gives zero. The shift amount is the low log2(XLEN) bits of b. The upper bits of b have no effect.
- R6: The memory-stage result select `ex_res_sel` picks 0 the adder result, 1 the logic result, 2 the shifter result, or 3 zero. It uses the codes captured with the same instruction.
- R7: `mem_addr` equals the adder result of the instruction in the memory stage, whatever that instruction's result and writeback select codes are.
- R8: The writeback select `ex_wb_sel` picks 0 the memory-stage result, 1 `wb_load_data` as driven during the writeback cycle, 2 that instruction's `ex_pc` plus 4, or 3 zero.
- R9: Back-to-back instructions with different op and select codes each produce their own result, with no mixing of codes between stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | An instruction is present in execute |
| ex_a | input | XLEN | First operand |
| ex_b | input | XLEN | Second operand; its low bits are the shift amount |
| ex_pc | input | XLEN | Program counter of the instruction |
| ex_add_op | input | 2 | Adder operation code |
| ex_logic_op | input | 2 | Logic unit operation code |
| ex_shift_op | input | 2 | Shifter operation code |
| ex_res_sel | input | 2 | Memory-stage result select code |
| ex_wb_sel | input | 2 | Writeback select code |
| mem_valid | output | 1 | Memory stage holds an instruction |
| mem_addr | output | XLEN | Registered adder result, used as the access address |
| wb_load_data | input | XLEN | Load data for the instruction in writeback |
| wb_valid | output | 1 | Writeback stage holds an instruction |
| wb_data | output | XLEN | Register write data |

## Verification
`mem_addr` and `mem_valid` are due one rising edge after an instruction is driven. `wb_valid` and `wb_data` are due two edges after it. `wb_data` also follows `wb_load_data` within the same cycle. The bench drives a new instruction at every falling edge and keeps a two-deep model of the stage contents. At each falling edge it first drives the load data for the instruction in writeback, waits a moment, then compares the memory-stage outputs against the instruction driven one cycle earlier and the writeback outputs against the one driven two cycles earlier. Only then does it drive the next instruction. All op and select code combinations are swept back to back with corner operands and bubbles, followed by random traffic.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;
   typedef enum logic [1:0] {ADD_PLUS, ADD_MINUS, ADD_LT_S, ADD_LT_U} add_op_e;
   typedef enum logic [1:0] {LOG_XOR, LOG_OR, LOG_AND, LOG_ZERO} logic_op_e;
   typedef enum logic [1:0] {SH_LEFT, SH_RIGHT_L, SH_RIGHT_A, SH_ZERO} shift_op_e;
   typedef enum logic [1:0] {RES_ADDER, RES_LOGIC, RES_SHIFT, RES_ZERO} res_sel_e;
   typedef enum logic [1:0] {WB_RESULT, WB_LOAD, WB_LINK, WB_ZERO} wb_sel_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder
   import split_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  add_op_e         op,
   output logic [XLEN-1:0] y
);
   logic            subtract;
   logic [XLEN-1:0] b_eff;
   logic [XLEN:0]   full;
   logic            lt_signed;
   logic            lt_unsigned;

   always_comb begin
      subtract    = (op != ADD_PLUS);
      b_eff       = subtract ? ~b : b;
      full        = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, subtract};
      // no carry out of a + ~b + 1 means a borrowed
      lt_unsigned = ~full[XLEN];
      lt_signed   = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : full[XLEN-1];
      unique case (op)
         ADD_LT_S: y = {{(XLEN-1){1'b0}}, lt_signed};
         ADD_LT_U: y = {{(XLEN-1){1'b0}}, lt_unsigned};
         default:  y = full[XLEN-1:0];
      endcase
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import split_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic_op_e       op,
   output logic [XLEN-1:0] y
);
   always_comb begin
      unique case (op)
         LOG_XOR: y = a ^ b;
         LOG_OR:  y = a | b;
         LOG_AND: y = a & b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import split_alu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [XLEN-1:0]         a,
   input  logic [$clog2(XLEN)-1:0] amt,
   input  shift_op_e               op,
   output logic [XLEN-1:0]         y
);
   localparam int SHW = $clog2(XLEN);

   logic left;
   logic fill;
   logic [XLEN-1:0] shifted;

   always_comb begin
      left = (op == SH_LEFT);
      fill = (op == SH_RIGHT_A) & a[XLEN-1];
   end

   generate
      if (LOG_STAGES) begin : g_log
         logic [XLEN-1:0] stg [SHW+1];
         assign stg[0] = a;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int S = 1 << k;
            always_comb begin
               if (!amt[k])
                  stg[k+1] = stg[k];
               else if (left)
                  stg[k+1] = {stg[k][XLEN-1-S:0], {S{1'b0}}};
               else
                  stg[k+1] = {{S{fill}}, stg[k][XLEN-1:S]};
            end
         end
         assign shifted = stg[SHW];
      end else begin : g_op
         always_comb begin
            if (left) shifted = a << amt;
            else      shifted = {{XLEN{fill}}, a} >> amt;
         end
      end
   endgenerate

   assign y = (op == SH_ZERO) ? '0 : shifted;
endmodule

// File: rtl/split_alu_dp.sv
module split_alu_dp
   import split_alu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_valid,
   input  logic [XLEN-1:0] ex_a,
   input  logic [XLEN-1:0] ex_b,
   input  logic [XLEN-1:0] ex_pc,
   input  logic [1:0]      ex_add_op,
   input  logic [1:0]      ex_logic_op,
   input  logic [1:0]      ex_shift_op,
   input  logic [1:0]      ex_res_sel,
   input  logic [1:0]      ex_wb_sel,
   output logic            mem_valid,
   output logic [XLEN-1:0] mem_addr,
   input  logic [XLEN-1:0] wb_load_data,
   output logic            wb_valid,
   output logic [XLEN-1:0] wb_data
);
   localparam int SHW = $clog2(XLEN);

   generate
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("split_alu_dp: XLEN must be a power of two, at least 8");
      end
   endgenerate

   // ---------------- execute: three units in parallel ----------------
   logic [XLEN-1:0] x_add, x_logic, x_shift, x_link;

   alu_adder #(.XLEN(XLEN)) u_adder (
      .a(ex_a), .b(ex_b), .op(add_op_e'(ex_add_op)), .y(x_add));

   alu_logic #(.XLEN(XLEN)) u_logic (
      .a(ex_a), .b(ex_b), .op(logic_op_e'(ex_logic_op)), .y(x_logic));

   alu_shifter #(.XLEN(XLEN), .LOG_STAGES(LOG_STAGES)) u_shift (
      .a(ex_a), .amt(ex_b[SHW-1:0]), .op(shift_op_e'(ex_shift_op)), .y(x_shift));

   assign x_link = ex_pc + XLEN'(4);

   // ---------------- execute -> memory registers ----------------
   logic            m_valid_q;
   logic [XLEN-1:0] m_add_q, m_logic_q, m_shift_q, m_link_q;
   res_sel_e        m_res_sel_q;
   wb_sel_e         m_wb_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid_q   <= 1'b0;
         m_add_q     <= '0;
         m_logic_q   <= '0;
         m_shift_q   <= '0;
         m_link_q    <= '0;
         m_res_sel_q <= RES_ADDER;
         m_wb_sel_q  <= WB_RESULT;
      end else begin
         m_valid_q   <= ex_valid;
         m_add_q     <= x_add;
         m_logic_q   <= x_logic;
         m_shift_q   <= x_shift;
         m_link_q    <= x_link;
         m_res_sel_q <= res_sel_e'(ex_res_sel);
         m_wb_sel_q  <= wb_sel_e'(ex_wb_sel);
      end
   end

   // ---------------- memory: deferred result select ----------------
   logic [XLEN-1:0] m_result;

   always_comb begin
      unique case (m_res_sel_q)
         RES_ADDER: m_result = m_add_q;
         RES_LOGIC: m_result = m_logic_q;
         RES_SHIFT: m_result = m_shift_q;
         default:   m_result = '0;
      endcase
   end

   assign mem_valid = m_valid_q;
   assign mem_addr  = m_add_q;   // address tapped before the result mux

   // ---------------- memory -> writeback registers ----------------
   logic            w_valid_q;
   logic [XLEN-1:0] w_result_q, w_link_q;
   wb_sel_e         w_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_valid_q  <= 1'b0;
         w_result_q <= '0;
         w_link_q   <= '0;
         w_sel_q    <= WB_RESULT;
      end else begin
         w_valid_q  <= m_valid_q;
         w_result_q <= m_result;
         w_link_q   <= m_link_q;
         w_sel_q    <= m_wb_sel_q;
      end
   end

   // ---------------- writeback: deferred write-data select ----------------
   always_comb begin
      unique case (w_sel_q)
         WB_RESULT: wb_data = w_result_q;
         WB_LOAD:   wb_data = wb_load_data;
         WB_LINK:   wb_data = w_link_q;
         default:   wb_data = '0;
      endcase
   end

   assign wb_valid = w_valid_q;

   // ---------------- assertions ----------------
   p_mem_follows_ex_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid |=> mem_valid);

   p_wb_follows_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |=> wb_valid);

   p_bubble_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |=> !mem_valid);

   p_addr_is_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_add_op == 2'd0) |=> mem_addr == $past(ex_a) + $past(ex_b));

   p_compare_is_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_add_op[1]) |=> mem_addr[XLEN-1:1] == '0);

   p_link_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_wb_sel == 2'd2) |=> ##1 wb_data == $past(ex_pc, 2) + XLEN'(4));
endmodule

// File: tb/tb_split_alu_dp.sv
`timescale 1ns/1ps
module tb_split_alu_dp;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ex_valid = 1'b0;
   logic [XLEN-1:0] ex_a = '0, ex_b = '0, ex_pc = '0;
   logic [1:0]      ex_add_op = '0, ex_logic_op = '0, ex_shift_op = '0;
   logic [1:0]      ex_res_sel = '0, ex_wb_sel = '0;
   logic            mem_valid, wb_valid;
   logic [XLEN-1:0] mem_addr, wb_data;
   logic [XLEN-1:0] wb_load_data = '0;

   always #2 clk = ~clk;   // 250 MHz

   split_alu_dp #(.XLEN(XLEN)) dut (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid),
      .ex_a(ex_a), .ex_b(ex_b), .ex_pc(ex_pc),
      .ex_add_op(ex_add_op), .ex_logic_op(ex_logic_op), .ex_shift_op(ex_shift_op),
      .ex_res_sel(ex_res_sel), .ex_wb_sel(ex_wb_sel),
      .mem_valid(mem_valid), .mem_addr(mem_addr),
      .wb_load_data(wb_load_data), .wb_valid(wb_valid), .wb_data(wb_data));

   typedef struct {
      logic            v;
      logic [XLEN-1:0] a, b, pc, ld;
      logic [1:0]      aop, lop, sop, rsel, wsel;
   } ins_t;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   ins_t pm, pw;   // instructions expected in memory and writeback

   task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                      input logic [XLEN-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [XLEN-1:0] m_add(input ins_t i);
      case (i.aop)
         2'd0: return i.a + i.b;
         2'd1: return i.a - i.b;
         2'd2: return ($signed(i.a) < $signed(i.b)) ? 1 : 0;
         default: return (i.a < i.b) ? 1 : 0;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] m_res(input ins_t i);
      int sh;
      sh = int'(i.b[4:0]);
      case (i.rsel)
         2'd0: return m_add(i);
         2'd1: case (i.lop)
                  2'd0: return i.a ^ i.b;
                  2'd1: return i.a | i.b;
                  2'd2: return i.a & i.b;
                  default: return '0;
               endcase
         2'd2: case (i.sop)
                  2'd0: return i.a << sh;
                  2'd1: return i.a >> sh;
                  2'd2: return $unsigned($signed(i.a) >>> sh);
                  default: return '0;
               endcase
         default: return '0;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] m_wb(input ins_t i);
      case (i.wsel)
         2'd0: return m_res(i);
         2'd1: return i.ld;
         2'd2: return i.pc + 4;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_addr(input ins_t i);
      return (i.aop[1]) ? "R3,R7" : "R2,R7";
   endfunction

   function automatic string tag_wb(input ins_t i);
      if (i.wsel != 2'd0) return "R8,R9";
      case (i.rsel)
         2'd0: return i.aop[1] ? "R3,R6,R9" : "R2,R6,R9";
         2'd1: return "R4,R6,R9";
         2'd2: return "R5,R6,R9";
         default: return "R6,R9";
      endcase
   endfunction

   // one cycle: check stage outputs, then drive next instruction
   task automatic step(input ins_t n);
      @(negedge clk);
      wb_load_data = pw.ld;
      #0.5;
      chk(mem_valid == pm.v, "R1 mem_valid", {31'd0, mem_valid}, {31'd0, pm.v});
      if (pm.v) chk(mem_addr == m_add(pm), tag_addr(pm), mem_addr, m_add(pm));
      chk(wb_valid == pw.v, "R1 wb_valid", {31'd0, wb_valid}, {31'd0, pw.v});
      if (pw.v) chk(wb_data == m_wb(pw), tag_wb(pw), wb_data, m_wb(pw));
      ex_valid    = n.v;
      ex_a        = n.a;
      ex_b        = n.b;
      ex_pc       = n.pc;
      ex_add_op   = n.aop;
      ex_logic_op = n.lop;
      ex_shift_op = n.sop;
      ex_res_sel  = n.rsel;
      ex_wb_sel   = n.wsel;
      pw = pm;
      pm = n;
   endtask

   function automatic logic [XLEN-1:0] corner(input int k);
      case (k % 8)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h7FFF_FFFF;
         5: return 32'hFFFF_FFE0;   // shift amount 0, upper bits set
         6: return 32'hA5A5_A55F;   // shift amount 31
         default: return 32'h1234_5678;
      endcase
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      ins_t n;
      pm = '{default: '0};
      pw = '{default: '0};
      n  = '{default: '0};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_valid == 1'b0, "R1 reset mem_valid", {31'd0, mem_valid}, '0);
      chk(wb_valid == 1'b0, "R1 reset wb_valid", {31'd0, wb_valid}, '0);
      rst_n = 1'b1;

      // sweep every code combination back to back (R9), with bubbles
      for (int i = 0; i < 1024; i++) begin
         n.v    = (i % 7) != 6;
         n.a    = corner(i) ^ (i[0] ? 32'h0 : 32'h0000_0100);
         n.b    = corner(i / 8 + i / 3);
         n.pc   = 32'h0000_1000 + 32'(i * 4);
         n.ld   = 32'hC0DE_0000 + 32'(i);
         n.aop  = i[1:0];
         n.lop  = i[3:2];
         n.sop  = i[5:4];
         n.rsel = i[7:6];
         n.wsel = i[9:8];
         step(n);
      end

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         n.v    = ($urandom % 5) != 0;
         n.a    = $urandom;
         n.b    = $urandom;
         n.pc   = $urandom & 32'hFFFF_FFFC;
         n.ld   = $urandom;
         n.aop  = 2'($urandom);
         n.lop  = 2'($urandom);
         n.sop  = 2'($urandom);
         n.rsel = 2'($urandom);
         n.wsel = 2'($urandom);
         step(n);
      end

      // drain with bubbles
      n = '{default: '0};
      repeat (3) step(n);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule